// File: doc/BRIEF.md
# Column-Counting Unsigned Multiplier

This block multiplies two unsigned operands with no clock and presents the full double-width product. It first builds an AND-gate matrix of partial products: row j is the multiplicand gated by multiplier bit j and moved left by j places, with zeros in the low places it leaves. The product is then formed one output column at a time. Each column counts the ones among its own partial-product bits and all carry bits sent to it from lower columns.

The count of a column is a small binary number. Its least significant bit is the product bit of that column. Its bit of weight 2 goes to the next column up, its bit of weight 4 goes two columns up, and so on. A single ripple carry is therefore never used between columns. The number of carry lines entering a column rises toward the middle of the product, where the partial-product columns are tallest. The operand width is a parameter, and all column sizes and carry routes are derived from it at elaboration.

Top module: `colcount_mult`

## Requirements
- R1: For every pair of unsigned operands, `product_o` equals the exact unsigned product of `mcand_i` and `mplier_i`, all 2*OP_W bits wide, with nothing truncated.
- R2: When either operand is zero, every bit of `product_o` is zero.
- R3: No column count has a bit whose weight lands beyond the top product bit. The largest case, 255 x 255, gives 65025 exactly.
- R4: When the multiplier is 2^k (only bit k set), the product is the multiplicand shifted left by k places, with zeros in the k lowest bits.
- R5: 245 x 175 gives 42875.
- R6: A column that holds more than three ones sends carries of weight 4 and higher onward correctly. Operand patterns with dense ones, such as 0xFF x 0xFF and 0xF5 x 0xAF, give exact results.
- R7: Swapping the operands leaves the product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | OP_W (8) | Unsigned multiplicand |
| mplier_i | input | OP_W (8) | Unsigned multiplier |
| product_o | output | 2*OP_W (16) | Unsigned product, full width |

## Verification
The hardest case for this block is a middle column where carries of weight 2 and weight 4 arrive together from two different lower columns, at the same moment as that column's own tallest stack of partial products. A wrong route or slot for either carry changes the count. Dense-ones operands such as 0xFF x 0xFF and 0xF5 x 0xAF make this happen, and a sweep over all 65536 operand pairs covers every mix of the two. Each result is compared with a product the bench computes arithmetically, so a dropped or misweighted carry shows up as a mismatch in the exact column it affects.

// File: rtl/colcount_pkg.sv
package colcount_pkg;

    localparam int unsigned DEF_OP_W = 8;
    localparam int          MAX_COLS = 64;

    // Number of bits needed to hold the value n.
    function automatic int bits_for(input int n);
        int b;
        b = 0;
        while ((1 << b) <= n) b++;
        return b;
    endfunction

    // Partial-product bits that fall into column c.
    function automatic int pp_in_col(input int w, input int c);
        int n;
        n = 0;
        for (int r = 0; r < w; r++)
            if ((c - r) >= 0 && (c - r) < w) n++;
        return n;
    endfunction

    // Total inputs of column c: its partial products plus arriving carries.
    function automatic int inputs_of_col(input int w, input int c);
        int n [MAX_COLS];
        for (int j = 0; j < MAX_COLS; j++) n[j] = 0;
        for (int j = 0; j <= c; j++) begin
            n[j] = pp_in_col(w, j);
            for (int k = 1; k <= j; k++)
                if (bits_for(n[j-k]) > k) n[j]++;
        end
        return n[c];
    endfunction

    function automatic int width_of_col(input int w, input int c);
        return bits_for(inputs_of_col(w, c));
    endfunction

    // Input slot of partial product row r within column c.
    function automatic int pp_slot(input int w, input int c, input int r);
        return r - (((c - w + 1) > 0) ? (c - w + 1) : 0);
    endfunction

    // Input slot of the carry of weight 2^k coming from column c-k.
    function automatic int carry_slot(input int w, input int c, input int k);
        int s;
        s = pp_in_col(w, c);
        for (int kk = 1; kk < k; kk++)
            if (width_of_col(w, c - kk) > kk) s++;
        return s;
    endfunction

endpackage

// File: rtl/pp_matrix.sv
module pp_matrix #(
    parameter int unsigned W = colcount_pkg::DEF_OP_W
) (
    input  logic [W-1:0]         mcand,
    input  logic [W-1:0]         mplier,
    output logic [W-1:0][W-1:0]  rows
);
    // Row j: multiplicand gated by multiplier bit j (shift applied by column routing).
    for (genvar j = 0; j < W; j++) begin : row_g
        assign rows[j] = mcand & {W{mplier[j]}};
    end
endmodule

// File: rtl/col_counter.sv
module col_counter #(
    parameter int unsigned N  = 3,
    parameter int unsigned OW = 2
) (
    input  logic [N-1:0]  bits_in,
    output logic [OW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < int'(N); i++)
            count = count + OW'(bits_in[i]);
    end
endmodule

// File: rtl/colcount_mult.sv
module colcount_mult #(
    parameter int unsigned OP_W = colcount_pkg::DEF_OP_W
) (
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic [2*OP_W-1:0] product_o
);
    import colcount_pkg::*;

    localparam int PW = 2 * OP_W;

    logic [OP_W-1:0][OP_W-1:0] rows;
    logic [PW-1:0]             ovf_bits;

    pp_matrix #(.W(OP_W)) u_pp (
        .mcand  (mcand_i),
        .mplier (mplier_i),
        .rows   (rows)
    );

    for (genvar c = 0; c < PW; c++) begin : col_g
        localparam int NI  = inputs_of_col(OP_W, c);
        localparam int NIS = (NI > 0) ? NI : 1;
        localparam int OW  = bits_for(NIS);
        localparam int TOP = PW - c;

        logic [NIS-1:0] vin;
        logic [OW-1:0]  cnt;

        if (NI == 0) begin : empty_g
            assign vin = '0;
        end else begin : fill_g
            // Partial-product bits of this column.
            for (genvar r = 0; r < OP_W; r++) begin : pp_g
                if ((c - r) >= 0 && (c - r) < OP_W) begin : hit_g
                    assign vin[pp_slot(OP_W, c, r)] = rows[r][c-r];
                end
            end
            // Carry bit of weight 2^k from column c-k.
            for (genvar k = 1; k <= c; k++) begin : cy_g
                if (width_of_col(OP_W, c - k) > k) begin : hit_g
                    assign vin[carry_slot(OP_W, c, k)] = col_g[c-k].cnt[k];
                end
            end
        end

        col_counter #(.N(NIS), .OW(OW)) u_cnt (
            .bits_in (vin),
            .count   (cnt)
        );

        assign product_o[c] = cnt[0];

        if (OW > TOP) begin : ovf_g
            assign ovf_bits[c] = |cnt[OW-1:TOP];
        end else begin : noovf_g
            assign ovf_bits[c] = 1'b0;
        end
    end

    // Checks on the settled column network.
    always_comb begin
        p_full_product_r1: assert (product_o == (PW'(mcand_i) * PW'(mplier_i)))
            else $error("R1 product mismatch");
        p_zero_operand_r2: assert (!((mcand_i == '0) || (mplier_i == '0)) || (product_o == '0))
            else $error("R2 zero operand gave nonzero product");
        p_no_overflow_r3: assert (ovf_bits == '0)
            else $error("R3 carry beyond top column");
        for (int i = 0; i < int'(OP_W); i++) begin
            // R4: single-bit multiplier acts as a shift
            if (mplier_i == (OP_W'(1) << i))
                p_pow2_shift_r4: assert (product_o == (PW'(mcand_i) << i))
                    else $error("R4 power-of-two shift mismatch");
        end
    end
endmodule

// File: tb/colcount_mult_test.sv
module colcount_mult_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int PW = 16;
    localparam int WATCHDOG_CYCLES = 150000;

    typedef struct {
        logic [PW-1:0] expected;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        string         req;
    } item_t;

    logic          clk = 1'b0;
    logic [W-1:0]  mcand;
    logic [W-1:0]  mplier;
    logic [PW-1:0] product;

    item_t sb_q [$];
    int    n_compared = 0;
    int    n_mismatch = 0;
    bit    drive_done = 1'b0;
    bit    finished   = 1'b0;

    colcount_mult #(.OP_W(W)) uut (
        .mcand_i   (mcand),
        .mplier_i  (mplier),
        .product_o (product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input int a, input int b, input logic [PW-1:0] exp_p, input string req);
        item_t it;
        @(posedge clk);
        mcand  <= W'(a);
        mplier <= W'(b);
        it.expected = exp_p;
        it.a = W'(a);
        it.b = W'(b);
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, after inputs settled.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_compared++;
            if (product !== it.expected) begin
                n_mismatch++;
                $display("FAIL %s: %0d x %0d actual %0d expected %0d",
                         it.req, it.a, it.b, product, it.expected);
            end
        end
    end

    initial begin
        mcand  = '0;
        mplier = '0;
        // Idle state: both operands zero (R2)
        drive(0, 0, 16'd0, "R2");
        drive(0, 255, 16'd0, "R2");
        drive(173, 0, 16'd0, "R2");
        // R5 known pair
        drive(245, 175, 16'd42875, "R5");
        // R3 largest product
        drive(255, 255, 16'd65025, "R3");
        // R6 dense ones
        drive(8'hFF, 8'hFF, 16'd65025, "R6");
        drive(8'hF5, 8'hAF, 16'd42875, "R6");
        drive(8'hFE, 8'h7F, 16'd32258, "R6");
        // R4 powers of two as multiplier
        for (int k = 0; k < W; k++)
            drive(8'hB7, 1 << k, 16'(183 << k), "R4");
        // R7 swapped operands
        drive(175, 245, 16'd42875, "R7");
        drive(19, 201, 16'd3819, "R7");
        drive(201, 19, 16'd3819, "R7");
        // R1 exhaustive sweep
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                drive(x, y, 16'(x * y), "R1");
        drive_done = 1'b1;
    end

    initial begin
        wait (drive_done);
        wait (sb_q.size() == 0);
        @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_mismatch);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_compared++;
            n_mismatch++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_mismatch);
            $finish;
        end
    end
endmodule